// File: doc/BRIEF.md
# Dock loop counter and flag unit

This unit holds the control state of one dataflow dock: an outer loop counter, an inner repeat counter that can also hold "forever", and four one-bit flags named A, B, C and D. Each cycle it may receive one decoded instruction. The instruction can load or decrement the outer counter, load the inner counter, rewrite flags A and B, or report that a move has completed. Every instruction carries a one-hot skip mask that is tested against the current flags, and the unit reports at once whether the instruction executes.

A move sequencer beside the unit reads the inner counter to learn how many times the next move repeats: zero, a count, or forever. When the move finishes it sends a move-completion instruction to this unit. That instruction updates C and, optionally, D. A torpedo input can end a move that is not immune; the unit acknowledges it and leaves C and D alone. The dock direction (input or output) is a strap input.

Top module: `loopflag_unit`

## Requirements
- R1: A synchronous reset sets both counters to 0, clears the forever state and clears flags A, B, C and D.
- R2: `exec` is 1 when `ins_valid` is 1 and no mask condition holds. The mask `ins_pred[5:0]` is ordered {D, not D, not B, B, not A, A} from bit 5 down, and a 1 bit means "skip if this condition is true". `ins_kind` is one-hot: bit 0 outer counter, bit 1 inner counter, bit 2 set-flags/abort, bit 3 move completion.
- R3: An instruction that is skipped changes no counter and no flag.
- R4: An executed outer-counter instruction with `ins_src`=0 loads `ins_imm`. With `ins_src`=1 it loads the low 6 bits of `dlatch`.
- R5: An outer-counter instruction with `ins_src`=2 decrements the counter by one, and the counter stays at 0 when it is already 0.
- R6: An executed inner-counter instruction loads `ins_imm` when `ins_src[0]`=0 and the low bits of `dlatch` when it is 1. When `ins_inf`=1 it sets the forever state instead, whatever `ins_src` is, and `rep_count` then reads 0.
- R7: `rep_count` and `rep_forever` always show the stored inner counter and the forever state.
- R8: Set-flags computes the new A as the OR of the conditions selected by `ins_fa`, and the new B the same way from `ins_fb`. Each mask is ordered {not C, C, not B, B, not A, A} from bit 5 down. Both results use the flag values from before the instruction.
- R9: Abort (`ins_fa`=6'b000001, `ins_fb`=6'b000100) executes as a set-flags instruction and leaves all four flags unchanged.
- R10: A completed move sets C from `ship_c` when `out_dock`=1 and `mv_dc`=1. Otherwise it sets C from `pkt_sig` when `mv_ti`=1, or when `mv_di`=1 and `out_dock`=0. In every other case C keeps its value.
- R11: A completed move with `mv_rd`=1 sets D to 1 when the outer counter was 0 and to 0 otherwise. With `mv_rd`=0, D keeps its value.
- R12: Any executed move completion, whether it ends normally or by torpedo, sets the inner counter to 1 and clears the forever state.
- R13: `torp_ack` is 1 when an executed move completion has `mv_immune`=0 and `torpedo`=1. In that case C and D are left unchanged. When `mv_immune`=1 the torpedo is ignored and the move updates C and D normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| ins_valid | input | 1 | Instruction present this cycle |
| ins_kind | input | 4 | One-hot instruction class |
| ins_pred | input | 6 | One-hot skip mask |
| ins_src | input | 2 | Counter source select |
| ins_imm | input | CNT_W | Counter immediate |
| ins_inf | input | 1 | Load forever into inner counter |
| ins_fa | input | 6 | Flag A update mask |
| ins_fb | input | 6 | Flag B update mask |
| mv_ti | input | 1 | Move takes a token in |
| mv_di | input | 1 | Move takes data in |
| mv_dc | input | 1 | C from ship at an output dock |
| mv_rd | input | 1 | Recompute D on this move |
| mv_immune | input | 1 | Move cannot be torpedoed |
| out_dock | input | 1 | Strap: 1 for an output dock |
| ship_c | input | 1 | C value supplied by the ship |
| pkt_sig | input | 1 | Signal bit of the arriving packet |
| dlatch | input | DW | Data latch contents |
| torpedo | input | 1 | Torpedo request |
| exec | output | 1 | Instruction executes (not skipped) |
| torp_ack | output | 1 | Torpedo has ended this move |
| rep_count | output | CNT_W | Inner repeat count |
| rep_forever | output | 1 | Inner counter holds forever |
| olc | output | CNT_W | Outer loop counter |
| flag_a | output | 1 | Flag A |
| flag_b | output | 1 | Flag B |
| flag_c | output | 1 | Flag C |
| flag_d | output | 1 | Flag D |

## Verification
The skip logic is swept over all 64 mask values in each of the eight combinations of A, B and D. This shows that every mask bit is tied to the correct condition and polarity, and that several set bits combine with OR. Set-flags is driven with masks that swap A and B, so an update that read freshly written values would give a different result from one that reads the old values. Moves are run under every C-source case at both dock directions, with D recomputed against a zero and a nonzero outer counter. Torpedoes are sent to both immune and non-immune moves. Each class of instruction is also sent with a mask that forces a skip, to show that no state moves.

// File: rtl/loopflag_unit.sv
module loopflag_unit #(
  parameter int CNT_W = 6,
  parameter int DW    = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ins_valid,
  input  logic [3:0]       ins_kind,
  input  logic [5:0]       ins_pred,
  input  logic [1:0]       ins_src,
  input  logic [CNT_W-1:0] ins_imm,
  input  logic             ins_inf,
  input  logic [5:0]       ins_fa,
  input  logic [5:0]       ins_fb,
  input  logic             mv_ti,
  input  logic             mv_di,
  input  logic             mv_dc,
  input  logic             mv_rd,
  input  logic             mv_immune,
  input  logic             out_dock,
  input  logic             ship_c,
  input  logic             pkt_sig,
  input  logic [DW-1:0]    dlatch,
  input  logic             torpedo,
  output logic             exec,
  output logic             torp_ack,
  output logic [CNT_W-1:0] rep_count,
  output logic             rep_forever,
  output logic [CNT_W-1:0] olc,
  output logic             flag_a,
  output logic             flag_b,
  output logic             flag_c,
  output logic             flag_d
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] olc_q, ilc_q;
  logic inf_q, a_q, b_q, c_q, d_q;

  wire [5:0] cond_p = {d_q, ~d_q, ~b_q, b_q, ~a_q, a_q};
  wire [5:0] cond_f = {~c_q, c_q, ~b_q, b_q, ~a_q, a_q};
  wire [CNT_W-1:0] dl_cnt = dlatch[CNT_W-1:0];
  wire unused_dl = ^dlatch;

  assign exec = ins_valid & ~|(ins_pred & cond_p);

  wire do_olc = exec & ins_kind[0];
  wire do_ilc = exec & ins_kind[1];
  wire do_flg = exec & ins_kind[2];
  wire do_mv  = exec & ins_kind[3];

  assign torp_ack = do_mv & torpedo & ~mv_immune;

  wire c_ship = out_dock & mv_dc;
  wire c_pkt  = mv_ti | (~out_dock & mv_di);

  always_ff @(posedge clk) begin
    if (rst) begin
      olc_q <= '0;
      ilc_q <= '0;
      inf_q <= 1'b0;
      a_q   <= 1'b0;
      b_q   <= 1'b0;
      c_q   <= 1'b0;
      d_q   <= 1'b0;
    end else begin
      if (do_olc) begin
        case (ins_src)
          2'd0: olc_q <= ins_imm;
          2'd1: olc_q <= dl_cnt;
          2'd2: if (olc_q != '0) olc_q <= olc_q - ONE;
          default: ;
        endcase
      end
      if (do_ilc) begin
        if (ins_inf) begin
          inf_q <= 1'b1;
          ilc_q <= '0;
        end else begin
          inf_q <= 1'b0;
          ilc_q <= ins_src[0] ? dl_cnt : ins_imm;
        end
      end
      if (do_flg) begin
        a_q <= |(ins_fa & cond_f);
        b_q <= |(ins_fb & cond_f);
      end
      if (do_mv) begin
        ilc_q <= ONE;
        inf_q <= 1'b0;
        if (!torp_ack) begin
          if (c_ship)     c_q <= ship_c;
          else if (c_pkt) c_q <= pkt_sig;
          if (mv_rd)      d_q <= (olc_q == '0);
        end
      end
    end
  end

  assign olc         = olc_q;
  assign rep_count   = ilc_q;
  assign rep_forever = inf_q;
  assign flag_a      = a_q;
  assign flag_b      = b_q;
  assign flag_c      = c_q;
  assign flag_d      = d_q;

  p_kind_onehot_r2: assert property (@(posedge clk) disable iff (rst)
    ins_valid |-> $onehot0(ins_kind));

  p_skip_holds_r3: assert property (@(posedge clk) disable iff (rst)
    (ins_valid && !exec) |=> ($stable(olc) && $stable(rep_count) && $stable(rep_forever)
                              && $stable(flag_a) && $stable(flag_b) && $stable(flag_c) && $stable(flag_d)));

  p_dec_floor_r5: assert property (@(posedge clk) disable iff (rst)
    (exec && ins_kind[0] && ins_src == 2'd2) |=>
      (olc == (($past(olc) == '0) ? '0 : $past(olc) - ONE)));

  p_forever_kept_r6: assert property (@(posedge clk) disable iff (rst)
    (rep_forever && !(exec && (ins_kind[1] || ins_kind[3]))) |=> rep_forever);

  p_d_recompute_r11: assert property (@(posedge clk) disable iff (rst)
    (exec && ins_kind[3] && mv_rd && !torp_ack) |=> (flag_d == ($past(olc) == '0)));

  p_move_rearm_r12: assert property (@(posedge clk) disable iff (rst)
    (exec && ins_kind[3]) |=> (rep_count == ONE && !rep_forever));

  p_torp_keeps_cd_r13: assert property (@(posedge clk) disable iff (rst)
    torp_ack |=> ($stable(flag_c) && $stable(flag_d)));
endmodule

// File: tb/tb_loopflag_unit.sv
`timescale 1ns/100ps
module tb_loopflag_unit;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst;
  logic ins_valid;
  logic [3:0] ins_kind;
  logic [5:0] ins_pred;
  logic [1:0] ins_src;
  logic [5:0] ins_imm;
  logic ins_inf;
  logic [5:0] ins_fa, ins_fb;
  logic mv_ti, mv_di, mv_dc, mv_rd, mv_immune;
  logic out_dock, ship_c, pkt_sig, torpedo;
  logic [15:0] dlatch;
  logic exec, torp_ack, rep_forever, flag_a, flag_b, flag_c, flag_d;
  logic [5:0] rep_count, olc;

  loopflag_unit #(.CNT_W(6), .DW(16)) dut (
    .clk(clk), .rst(rst), .ins_valid(ins_valid), .ins_kind(ins_kind),
    .ins_pred(ins_pred), .ins_src(ins_src), .ins_imm(ins_imm), .ins_inf(ins_inf),
    .ins_fa(ins_fa), .ins_fb(ins_fb), .mv_ti(mv_ti), .mv_di(mv_di), .mv_dc(mv_dc),
    .mv_rd(mv_rd), .mv_immune(mv_immune), .out_dock(out_dock), .ship_c(ship_c),
    .pkt_sig(pkt_sig), .dlatch(dlatch), .torpedo(torpedo), .exec(exec),
    .torp_ack(torp_ack), .rep_count(rep_count), .rep_forever(rep_forever),
    .olc(olc), .flag_a(flag_a), .flag_b(flag_b), .flag_c(flag_c), .flag_d(flag_d));

  typedef struct {
    logic [5:0] olc;
    logic [5:0] ilc;
    logic       inf;
    logic [3:0] flags;
    string      req;
  } exp_t;

  exp_t sb_q[$];
  int n_chk = 0;
  int n_fail = 0;

  logic [5:0] m_olc, m_ilc;
  logic m_inf, m_a, m_b, m_c, m_d;

  task automatic chk(input bit ok, input string req, input string what, input int act, input int expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
    end
  endtask

  always @(negedge clk) begin
    if (sb_q.size() > 0) begin
      exp_t e;
      e = sb_q.pop_front();
      chk({olc, rep_count, rep_forever, flag_a, flag_b, flag_c, flag_d} ===
          {e.olc, e.ilc, e.inf, e.flags}, e.req, "state{olc,ilc,inf,abcd}",
          int'({olc, rep_count, rep_forever, flag_a, flag_b, flag_c, flag_d}),
          int'({e.olc, e.ilc, e.inf, e.flags}));
    end
  end

  task automatic clear_ins();
    ins_valid = 0; ins_kind = 0; ins_pred = 0; ins_src = 0; ins_imm = 0; ins_inf = 0;
    ins_fa = 0; ins_fb = 0; mv_ti = 0; mv_di = 0; mv_dc = 0; mv_rd = 0; mv_immune = 1;
    ship_c = 0; pkt_sig = 0; torpedo = 0;
  endtask

  task automatic step(input string req);
    exp_t e;
    logic sk, ta;
    logic [5:0] pv, fv;
    logic na, nb;
    pv = {m_d, ~m_d, ~m_b, m_b, ~m_a, m_a};
    fv = {~m_c, m_c, ~m_b, m_b, ~m_a, m_a};
    sk = |(ins_pred & pv);
    ta = !sk && ins_kind[3] && torpedo && !mv_immune;
    ins_valid = 1;
    #1;
    chk(exec === !sk, req, "exec", int'(exec), int'(!sk));
    chk(torp_ack === ta, req, "torp_ack", int'(torp_ack), int'(ta));
    if (!sk) begin
      if (ins_kind[0]) begin
        if (ins_src == 2'd0) m_olc = ins_imm;
        else if (ins_src == 2'd1) m_olc = dlatch[5:0];
        else if (ins_src == 2'd2) m_olc = (m_olc == 0) ? 6'd0 : m_olc - 6'd1;
      end
      if (ins_kind[1]) begin
        if (ins_inf) begin m_inf = 1; m_ilc = 0; end
        else begin m_inf = 0; m_ilc = ins_src[0] ? dlatch[5:0] : ins_imm; end
      end
      if (ins_kind[2]) begin
        na = |(ins_fa & fv);
        nb = |(ins_fb & fv);
        m_a = na;
        m_b = nb;
      end
      if (ins_kind[3]) begin
        if (!ta) begin
          if (out_dock && mv_dc) m_c = ship_c;
          else if (mv_ti || (!out_dock && mv_di)) m_c = pkt_sig;
          if (mv_rd) m_d = (m_olc == 0);
        end
        m_ilc = 1;
        m_inf = 0;
      end
    end
    e.olc = m_olc; e.ilc = m_ilc; e.inf = m_inf; e.flags = {m_a, m_b, m_c, m_d}; e.req = req;
    sb_q.push_back(e);
    @(posedge clk);
    @(negedge clk);
    clear_ins();
  endtask

  task automatic op_olc(input logic [1:0] src, input logic [5:0] imm, input logic [5:0] pred, input string req);
    ins_kind = 4'b0001; ins_src = src; ins_imm = imm; ins_pred = pred; step(req);
  endtask

  task automatic op_ilc(input logic [1:0] src, input logic [5:0] imm, input logic inf, input logic [5:0] pred, input string req);
    ins_kind = 4'b0010; ins_src = src; ins_imm = imm; ins_inf = inf; ins_pred = pred; step(req);
  endtask

  task automatic op_flags(input logic [5:0] fa, input logic [5:0] fb, input logic [5:0] pred, input string req);
    ins_kind = 4'b0100; ins_fa = fa; ins_fb = fb; ins_pred = pred; step(req);
  endtask

  task automatic op_move(input logic ti, input logic di, input logic dc, input logic rd,
                         input logic immune, input logic torp, input logic sc, input logic ps,
                         input logic [5:0] pred, input string req);
    ins_kind = 4'b1000; mv_ti = ti; mv_di = di; mv_dc = dc; mv_rd = rd; mv_immune = immune;
    torpedo = torp; ship_c = sc; pkt_sig = ps; ins_pred = pred; step(req);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    clear_ins();
    out_dock = 0;
    dlatch = 16'hABCD;
    rst = 1;
    m_olc = 0; m_ilc = 0; m_inf = 0; m_a = 0; m_b = 0; m_c = 0; m_d = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 0;
    chk({olc, rep_count, rep_forever, flag_a, flag_b, flag_c, flag_d} === 17'd0, "R1", "reset state",
        int'({olc, rep_count, rep_forever, flag_a, flag_b, flag_c, flag_d}), 0);

    op_olc(2'd0, 6'd37, 6'd0, "R4 imm");
    op_olc(2'd1, 6'd5, 6'd0, "R4 dlatch");
    op_olc(2'd0, 6'd2, 6'd0, "R4 imm2");
    op_olc(2'd2, 6'd0, 6'd0, "R5 dec");
    op_olc(2'd2, 6'd0, 6'd0, "R5 dec to zero");
    op_olc(2'd2, 6'd0, 6'd0, "R5 floor");

    op_ilc(2'd0, 6'd5, 1'b0, 6'd0, "R6 R7 imm");
    op_ilc(2'd1, 6'd9, 1'b0, 6'd0, "R6 R7 dlatch");
    op_ilc(2'd1, 6'd9, 1'b1, 6'd0, "R6 R7 forever");
    op_olc(2'd0, 6'd3, 6'd0, "R6 forever kept");
    op_move(0, 0, 0, 0, 1, 0, 0, 0, 6'd0, "R12 rearm from forever");
    op_ilc(2'd0, 6'd0, 1'b0, 6'd0, "R6 zero");
    op_move(0, 0, 0, 0, 1, 0, 0, 0, 6'd0, "R12 rearm from zero");

    op_flags(6'b110000, 6'b000000, 6'd0, "R8 force A1 B0");
    op_flags(6'b000100, 6'b000001, 6'd0, "R8 swap old values");
    op_flags(6'b000010, 6'b001000, 6'd0, "R8 notA and notB");
    op_flags(6'b000001, 6'b000100, 6'd0, "R9 abort");
    op_flags(6'b110000, 6'b110000, 6'd0, "R8 both one");
    op_flags(6'b000001, 6'b000100, 6'd0, "R9 abort set");

    op_move(1, 0, 0, 0, 1, 0, 0, 1, 6'd0, "R10 ti pkt");
    op_move(0, 1, 0, 0, 1, 0, 1, 0, 6'd0, "R10 di input dock");
    op_move(0, 0, 1, 0, 1, 0, 0, 1, 6'd0, "R10 dc at input dock ignored");
    op_flags(6'b010001, 6'b001000, 6'd0, "R8 from C");
    out_dock = 1;
    op_move(1, 0, 1, 0, 1, 0, 1, 0, 6'd0, "R10 ship priority");
    op_move(0, 1, 0, 0, 1, 0, 0, 0, 6'd0, "R10 di output dock ignored");
    op_move(1, 0, 0, 0, 1, 0, 1, 0, 6'd0, "R10 ti output dock");
    out_dock = 0;

    op_olc(2'd0, 6'd0, 6'd0, "R11 setup zero");
    op_move(0, 0, 0, 1, 1, 0, 0, 0, 6'd0, "R11 zero sets D");
    op_olc(2'd0, 6'd7, 6'd0, "R11 setup nonzero");
    op_move(0, 0, 0, 0, 1, 0, 0, 0, 6'd0, "R11 no rd keeps D");
    op_move(0, 0, 0, 1, 1, 0, 0, 0, 6'd0, "R11 nonzero clears D");

    op_ilc(2'd0, 6'd4, 1'b1, 6'd0, "R13 setup forever");
    op_olc(2'd0, 6'd0, 6'd0, "R13 setup olc");
    op_move(1, 0, 0, 1, 0, 1, 0, 1, 6'd0, "R13 torpedo taken");
    op_move(1, 0, 0, 1, 1, 1, 0, 1, 6'd0, "R13 immune ignores torpedo");
    op_move(0, 1, 0, 1, 0, 0, 0, 0, 6'd0, "R13 torpedoable no torpedo");

    op_flags(6'b110000, 6'b000000, 6'd0, "R3 setup A1 B0");
    op_olc(2'd0, 6'd50, 6'b000001, "R3 skip olc");
    op_olc(2'd2, 6'd0, 6'b001000, "R3 skip dec");
    op_ilc(2'd0, 6'd9, 1'b1, 6'b000001, "R3 skip ilc");
    op_flags(6'b000000, 6'b110000, 6'b000001, "R3 skip flags");
    op_move(1, 0, 0, 1, 1, 0, 0, 1, 6'b000001, "R3 skip move");

    for (int d = 0; d < 2; d++) begin
      for (int ab = 0; ab < 4; ab++) begin
        op_olc(2'd0, (d != 0) ? 6'd0 : 6'd1, 6'd0, "R2 setup olc");
        op_move(0, 0, 0, 1, 1, 0, 0, 0, 6'd0, "R2 setup D");
        op_flags(ab[1] ? 6'b110000 : 6'b000000, ab[0] ? 6'b110000 : 6'b000000, 6'd0, "R2 setup AB");
        for (int p = 0; p < 64; p++) begin
          op_flags(6'b000001, 6'b000100, 6'(p), "R2 mask sweep");
        end
      end
    end

    repeat (3) @(negedge clk);
    summary();
  end
endmodule